// File: doc/BRIEF.md
# Four-Channel Transfer Request Priority Resolver

This block picks which of four transfer request lines a DMA engine serves next. Each channel has a request bit and an enable bit. The enabled requests are resolved in one of two orders. In fixed order, the lowest-numbered channel wins. In rotating order, the channel after the most recently serviced one is highest, and the serviced channel drops to lowest.

The engine drives `sample_i` for one cycle at its sampling point near the end of each transfer. Only at that edge does the resolver record a winner. The recorded winner then applies to the following transfer. Between strobes, `grant_vld_o` and `grant_ch_o` hold their values whatever the requests, enables or mode do. The engine reports each completed transfer with a one-cycle `done_i` pulse and the channel number on `done_ch_i`. This moves a rotation pointer, in both modes.

A small state machine holds the grant. It has two states:
- `ST_IDLE`: no grant is held.
- `ST_HELD`: a winner is held.

Its transitions are:
- `GRANT` (`ST_IDLE` to `ST_HELD`): a strobe finds an enabled request.
- `REGRANT` (`ST_HELD` to `ST_HELD`): a strobe finds an enabled request while a grant is already held.
- `DROP` (`ST_HELD` to `ST_IDLE`): a strobe finds no enabled request.
- `WAIT` (stay in the current state): there is no strobe.

Top module: `dma_prio_arbiter`

## Requirements
- R1: After reset (active-low `rst_n`), `grant_vld_o` is 0 and `grant_ch_o` is 0. The rotation pointer makes channel 0 the highest priority.
- R2: In fixed mode (`rotate_i` = 0 at the strobe), the enabled requester with the lowest channel number wins.
- R3: A channel whose bit in `en_i` is 0 is never granted, even when its bit in `req_i` is 1.
- R4: In rotating mode (`rotate_i` = 1), the highest priority is the channel numbered one above the last serviced channel, wrapping from 3 to 0. Priority falls with rising number modulo 4, so the serviced channel is lowest.
- R5: `grant_vld_o` and `grant_ch_o` change only on a clock edge where `sample_i` is 1. They take their new values in the cycle after that edge.
- R6: A strobe that finds no enabled request clears `grant_vld_o`. `grant_ch_o` keeps its last value, and the rotation pointer is not changed.
- R7: A `done_i` pulse in the same cycle as `sample_i` is taken into account by that sample.
- R8: `done_i` moves the rotation pointer in fixed mode and with no strobe as well. A later rotating-mode strobe therefore starts after the last reported channel.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_i | input | NCH | Request per channel, bit n = channel n |
| en_i | input | NCH | Enable per channel, bit n = channel n |
| rotate_i | input | 1 | 0 = fixed order, 1 = rotating order |
| sample_i | input | 1 | One-cycle strobe at the sampling point of a transfer |
| done_i | input | 1 | One-cycle pulse: a transfer has completed |
| done_ch_i | input | CW | Channel whose transfer completed |
| grant_vld_o | output | 1 | A winner is held |
| grant_ch_o | output | CW | Number of the winning channel |

## Verification
A wrong rotation pointer stays hidden until the next rotating-mode strobe with several requests active. At that point it shows as a wrong `grant_ch_o` in the cycle after the strobe. The stimulus therefore moves the pointer in fixed mode, and without strobes, before rotating samples that tell the possible pointer values apart. A wrong grant state shows in `grant_vld_o` within one cycle of the faulty strobe. Any leak of request changes between strobes shows at once as an output that moves.

// File: rtl/dma_prio_pkg.sv
package dma_prio_pkg;

    // Grant holding states of the resolver
    typedef enum logic [0:0] {
        ST_IDLE = 1'b0,
        ST_HELD = 1'b1
    } arb_state_e;

    // Priority order selection
    typedef enum logic [0:0] {
        PRIO_FIXED  = 1'b0,
        PRIO_ROTATE = 1'b1
    } prio_mode_e;

endpackage

// File: rtl/prio_ptr_reg.sv
module prio_ptr_reg #(
    parameter int NCH = 4,
    parameter int CW  = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          done_i,
    input  logic [CW-1:0] done_ch_i,
    output logic [CW-1:0] ptr_q,
    output logic [CW-1:0] ptr_eff
);

    localparam logic [CW-1:0] LAST_CH = CW'(NCH - 1);

    logic [CW-1:0] ptr_next;

    // Channel after the serviced one becomes highest priority
    always_comb begin
        if (done_ch_i == LAST_CH) ptr_next = '0;
        else                      ptr_next = done_ch_i + 1'b1;
    end

    // A pulse in the current cycle is seen by a same-cycle sample
    always_comb begin
        ptr_eff = done_i ? ptr_next : ptr_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      ptr_q <= '0;
        else if (done_i) ptr_q <= ptr_next;
    end

    // R4 / R8: the pointer follows every serviced pulse
    assert_ptr_follow_R4: assert property (@(posedge clk) disable iff (!rst_n)
        done_i |=> ptr_q == (($past(done_ch_i) == LAST_CH) ? '0 : $past(done_ch_i) + 1'b1));

    // R6: without a serviced pulse the pointer stays put
    assert_ptr_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !done_i |=> $stable(ptr_q));

endmodule

// File: rtl/prio_pick.sv
module prio_pick #(
    parameter int NCH = 4,
    parameter int CW  = 2
) (
    input  logic [NCH-1:0] active_i,
    input  logic [CW-1:0]  base_i,
    output logic           hit_o,
    output logic [CW-1:0]  win_o
);

    logic [NCH-1:0] rot;
    logic [CW-1:0]  off;
    logic [CW:0]    wsum;

    // Rotate so that channel base_i lands at position 0
    for (genvar gi = 0; gi < NCH; gi++) begin : g_rot
        logic [CW:0] isum;
        logic [CW:0] iwrap;
        assign isum  = (CW+1)'(gi) + {1'b0, base_i};
        assign iwrap = (isum >= (CW+1)'(NCH)) ? isum - (CW+1)'(NCH) : isum;
        assign rot[gi] = active_i[iwrap[CW-1:0]];
    end

    // Lowest set position in the rotated vector
    always_comb begin
        off = '0;
        for (int i = NCH - 1; i >= 0; i--) begin
            if (rot[i]) off = CW'(i);
        end
    end

    always_comb begin
        hit_o = |active_i;
        wsum  = {1'b0, off} + {1'b0, base_i};
        if (wsum >= (CW+1)'(NCH)) wsum = wsum - (CW+1)'(NCH);
        win_o = wsum[CW-1:0];
    end

endmodule

// File: rtl/dma_prio_arbiter.sv
module dma_prio_arbiter
    import dma_prio_pkg::*;
#(
    parameter  int NCH = 4,
    localparam int CW  = (NCH > 1) ? $clog2(NCH) : 1
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [NCH-1:0] req_i,
    input  logic [NCH-1:0] en_i,
    input  logic           rotate_i,
    input  logic           sample_i,
    input  logic           done_i,
    input  logic [CW-1:0]  done_ch_i,
    output logic           grant_vld_o,
    output logic [CW-1:0]  grant_ch_o
);

    localparam logic [NCH-1:0] ONE = {{(NCH-1){1'b0}}, 1'b1};

    arb_state_e    state_q, state_d;
    logic [CW-1:0] ch_q, ch_d;
    logic [NCH-1:0] active;
    logic [CW-1:0] ptr_q, ptr_eff, base;
    logic          hit;
    logic [CW-1:0] win;
    prio_mode_e    mode;

    assign active = req_i & en_i;
    assign mode   = prio_mode_e'(rotate_i);

    prio_ptr_reg #(.NCH(NCH), .CW(CW)) i_ptr (
        .clk       (clk),
        .rst_n     (rst_n),
        .done_i    (done_i),
        .done_ch_i (done_ch_i),
        .ptr_q     (ptr_q),
        .ptr_eff   (ptr_eff)
    );

    always_comb begin
        unique case (mode)
            PRIO_FIXED:  base = '0;
            PRIO_ROTATE: base = ptr_eff;
        endcase
    end

    prio_pick #(.NCH(NCH), .CW(CW)) i_pick (
        .active_i (active),
        .base_i   (base),
        .hit_o    (hit),
        .win_o    (win)
    );

    // Next state: GRANT, REGRANT, DROP or WAIT
    always_comb begin
        state_d = state_q;
        ch_d    = ch_q;
        unique case (state_q)
            ST_IDLE: begin
                if (sample_i && hit) begin
                    state_d = ST_HELD;
                    ch_d    = win;
                end
            end
            ST_HELD: begin
                if (sample_i) begin
                    if (hit) begin
                        state_d = ST_HELD;
                        ch_d    = win;
                    end else begin
                        state_d = ST_IDLE;
                    end
                end
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            ch_q    <= '0;
        end else begin
            state_q <= state_d;
            ch_q    <= ch_d;
        end
    end

    always_comb begin
        grant_vld_o = (state_q == ST_HELD);
        grant_ch_o  = ch_q;
    end

    // R5: outputs move only after a strobe
    assert_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !sample_i |=> $stable(grant_vld_o) && $stable(grant_ch_o));

    // R6: an empty sample drops the grant
    assert_empty_drop_R6: assert property (@(posedge clk) disable iff (!rst_n)
        sample_i && !(|(req_i & en_i)) |=> !grant_vld_o);

    // R3: a held winner was enabled and requesting at the strobe
    assert_enabled_win_R3: assert property (@(posedge clk) disable iff (!rst_n)
        sample_i |=> !grant_vld_o || (|($past(req_i & en_i) & (ONE << grant_ch_o))));

    // R2: in fixed order no lower-numbered channel was active
    assert_fixed_lowest_R2: assert property (@(posedge clk) disable iff (!rst_n)
        sample_i && !rotate_i |=> !grant_vld_o ||
            (($past(req_i & en_i) & ((ONE << grant_ch_o) - ONE)) == '0));

endmodule

// File: tb/test_dma_prio_arbiter.sv
`timescale 1ns/1ps
module test_dma_prio_arbiter;

    typedef struct packed {
        logic       rot;
        logic [3:0] en;
        logic [3:0] req;
        logic       dn;
        logic [1:0] dch;
        logic       vld;
        logic [1:0] ch;
    } vec_t;

    localparam int NV = 14;

    localparam vec_t VECS [NV] = '{
        '{1'b0, 4'hF,    4'b1010, 1'b0, 2'd0, 1'b1, 2'd1},
        '{1'b0, 4'hF,    4'b1100, 1'b0, 2'd0, 1'b1, 2'd2},
        '{1'b0, 4'b1101, 4'b0110, 1'b0, 2'd0, 1'b1, 2'd2},
        '{1'b0, 4'b0011, 4'b1100, 1'b0, 2'd0, 1'b0, 2'd2},
        '{1'b1, 4'hF,    4'b1111, 1'b1, 2'd2, 1'b1, 2'd3},
        '{1'b1, 4'hF,    4'b1111, 1'b1, 2'd3, 1'b1, 2'd0},
        '{1'b1, 4'hF,    4'b0011, 1'b1, 2'd0, 1'b1, 2'd1},
        '{1'b1, 4'hF,    4'b0001, 1'b0, 2'd0, 1'b1, 2'd0},
        '{1'b1, 4'b1110, 4'b0001, 1'b1, 2'd1, 1'b0, 2'd0},
        '{1'b1, 4'hF,    4'b0111, 1'b0, 2'd0, 1'b1, 2'd2},
        '{1'b0, 4'hF,    4'b1100, 1'b1, 2'd3, 1'b1, 2'd2},
        '{1'b1, 4'hF,    4'b1001, 1'b0, 2'd0, 1'b1, 2'd0},
        '{1'b1, 4'hF,    4'b1010, 1'b1, 2'd1, 1'b1, 2'd3},
        '{1'b1, 4'hF,    4'b1010, 1'b1, 2'd3, 1'b1, 2'd1}
    };

    localparam string TAGS [NV] = '{
        "R2", "R2", "R3", "R6", "R7", "R4", "R4",
        "R4", "R6", "R6", "R2", "R8", "R4", "R4"
    };

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [3:0] req_i = '0;
    logic [3:0] en_i = '0;
    logic       rotate_i = 1'b0;
    logic       sample_i = 1'b0;
    logic       done_i = 1'b0;
    logic [1:0] done_ch_i = '0;
    logic       grant_vld_o;
    logic [1:0] grant_ch_o;

    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;

    dma_prio_arbiter #(.NCH(4)) i_dma_prio_arbiter (
        .clk         (clk),
        .rst_n       (rst_n),
        .req_i       (req_i),
        .en_i        (en_i),
        .rotate_i    (rotate_i),
        .sample_i    (sample_i),
        .done_i      (done_i),
        .done_ch_i   (done_ch_i),
        .grant_vld_o (grant_vld_o),
        .grant_ch_o  (grant_ch_o)
    );

    task automatic check(input string tag, input logic ev, input logic [1:0] ech);
        checks++;
        if (grant_vld_o !== ev || grant_ch_o !== ech) begin
            errors++;
            $display("FAIL %s: vld=%0b ch=%0d expected vld=%0b ch=%0d",
                     tag, grant_vld_o, grant_ch_o, ev, ech);
        end
    endtask

    // One strobe with the given inputs; outputs checked one cycle later
    task automatic strobe(input logic rot, input logic [3:0] en, input logic [3:0] req,
                          input logic dn, input logic [1:0] dch);
        @(negedge clk);
        rotate_i  = rot;
        en_i      = en;
        req_i     = req;
        done_i    = dn;
        done_ch_i = dch;
        sample_i  = 1'b1;
        @(negedge clk);
        sample_i = 1'b0;
        done_i   = 1'b0;
    endtask

    task automatic report;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: run did not end in time");
        report();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 reset outputs", 1'b0, 2'd0);
        // R1: pointer starts with channel 0 highest
        strobe(1'b1, 4'hF, 4'b1111, 1'b0, 2'd0);
        check("R1 reset pointer", 1'b1, 2'd0);

        for (int k = 0; k < NV; k++) begin
            strobe(VECS[k].rot, VECS[k].en, VECS[k].req, VECS[k].dn, VECS[k].dch);
            check(TAGS[k], VECS[k].vld, VECS[k].ch);
        end

        // R5: inputs churn without strobes, grant (ch1) must hold
        for (int k = 0; k < 5; k++) begin
            @(negedge clk);
            req_i    = 4'(k * 5 + 3);
            en_i     = 4'(15 - k);
            rotate_i = k[0];
            check("R5 hold between strobes", 1'b1, 2'd1);
        end

        // R8: serviced pulse alone moves the pointer, outputs untouched
        @(negedge clk);
        done_i    = 1'b1;
        done_ch_i = 2'd1;
        @(negedge clk);
        done_i = 1'b0;
        check("R5 done without strobe", 1'b1, 2'd1);
        strobe(1'b1, 4'hF, 4'b1111, 1'b0, 2'd0);
        check("R8 pointer after lone done", 1'b1, 2'd2);

        // R1: reset mid-run clears grant and pointer
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        check("R1 reset during run", 1'b0, 2'd0);
        rst_n = 1'b1;
        strobe(1'b1, 4'hF, 4'b1111, 1'b0, 2'd0);
        check("R1 pointer after second reset", 1'b1, 2'd0);

        report();
    end

endmodule